// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 operands and returns a 32-bit condition mask in which each bit holds one predicate about the pair. A width select picks single precision (the low 32 bits of each operand bus) or double precision (all 64 bits). A mode input picks a strict compare or a quiet compare. The strict compare flags invalid for any NaN. The quiet compare flags invalid only for a signaling NaN. A legacy input clears the extended predicate bits.

Besides the relational predicates, the mask carries interval bits. These place s1 relative to the closed range from zero to s2. The unit also registers a destination index with a write enable, so a register file can take the mask one cycle after the request. It only reports the invalid flag and takes no trap.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mask_q`, `invalid_q`, `wr_en_q` and `dst_q` are all zero.
- R2: A request presented on one rising edge appears on the outputs after that edge. `wr_en_q` is 1 only when `in_valid` was 1 and `dst_idx` was nonzero. `dst_q` echoes `dst_idx`. `invalid_q` is 0 for a cycle with `in_valid` low.
- R3: Single-precision NaN means exponent bits 30:23 are all ones and fraction bits 22:0 are nonzero. Double-precision NaN means bits 62:52 are all ones and bits 51:0 are nonzero. A NaN is signaling when its top fraction bit (bit 22 or bit 51) is 0.
- R4: If either operand is a NaN, the mask is 0x3D009. That value is bit0 unordered, bit3 not-equal, and bits 12, 14, 15, 16 and 17. No interval bits are set.
- R5: The strict compare (`quiet_cmp`=0) raises invalid for any NaN. The quiet compare raises invalid only for a signaling NaN, and the decision uses s1 alone whenever s1 is a NaN. For example, quiet s1 with signaling s2 gives no invalid.
- R6: Bit positions are: 1 ordered, 2 equal, 3 not-equal, 4 greater, 5 less-or-equal, 6 less, 7 greater-or-equal, 12 unordered-or-equal, 13 less-or-greater, 14 unordered-or-greater, 15 unordered-or-less-or-equal, 16 unordered-or-less, 17 unordered-or-greater-or-equal. Before interval bits are added, an equal result gives 0x290A6, a less result gives 0x1A06A and a greater result gives 0x2609A.
- R7: Ordering follows IEEE rules. +0 and -0 are equal. Any negative value is less than any positive value. Among negative values, the larger magnitude is the lesser value. Infinities order as the extreme values.
- R8: For an ordered result with the s2 sign bit clear, interval bits are added as follows. Bit8 is out-of-range, bit9 in-range-or-boundary, bit10 in-range and bit11 out-of-range-or-boundary. Equal operands or a zero s1 add 0xA00. Otherwise s1 greater than s2 adds 0x900, a positive s1 adds 0x600, and a negative s1 adds 0x900.
- R9: When the s2 sign bit is set, including s2 = -0, bits 11:8 are zero.
- R10: With `legacy` set, bits 17:12 are zero and all other bits are unchanged.
- R11: In single-precision mode, operand bits 63:32 have no effect on the result.
- R12: Bits 31:18 of the mask are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| dbl_sel | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| quiet_cmp | input | 1 | 1 = quiet compare, 0 = strict compare |
| legacy | input | 1 | Clears the extended bits 17:12 |
| opa | input | 64 | Operand s1 |
| opb | input | 64 | Operand s2 |
| dst_idx | input | 5 | Destination register index |
| mask_q | output | 32 | Registered condition mask |
| invalid_q | output | 1 | Registered invalid-operation flag |
| wr_en_q | output | 1 | Write enable for the mask |
| dst_q | output | 5 | Registered destination index |

## Verification
The main function is tried with operand pairs that hit each ordering outcome: positive pairs, negative pairs, mixed signs, signed zeros, infinities and a zero s1. These separate the magnitude-reversal path from the sign path and the zero-equality path. Interval patterns vary the sign of s2 (including -0) and the sign of s1, so each of the four interval encodings is reached. NaN patterns combine quiet and signaling NaNs in either operand under both compare modes, which tells apart the s1-first decision from a symmetric one. The legacy flag, double width and garbage in the upper half of the bus in single mode are each tried separately.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int MASK_W = 32;

    localparam int B_UN  = 0;
    localparam int B_ORD = 1;
    localparam int B_EQ  = 2;
    localparam int B_NE  = 3;
    localparam int B_GT  = 4;
    localparam int B_LE  = 5;
    localparam int B_LT  = 6;
    localparam int B_GE  = 7;
    localparam int B_OU  = 8;
    localparam int B_IB  = 9;
    localparam int B_IN  = 10;
    localparam int B_OB  = 11;
    localparam int B_UE  = 12;
    localparam int B_LG  = 13;
    localparam int B_UG  = 14;
    localparam int B_ULE = 15;
    localparam int B_UL  = 16;
    localparam int B_UGE = 17;
    localparam int EXT_LO = B_UE;
    localparam int EXT_HI = B_UGE;

    typedef struct packed {
        logic nan;
        logic snan;
        logic sign;
        logic zero;
    } fp_class_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } fp_order_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val,
    output fp_class_t    cls
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        expo     = val[W-2 -: EXP_W];
        frac     = val[FRAC_W-1:0];
        cls.nan  = (&expo) && (|frac);
        cls.snan = cls.nan && !frac[FRAC_W-1];
        cls.sign = val[W-1];
        cls.zero = ~|val[W-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_zero,
    input  logic         b_zero,
    output fp_order_t    ord
);
    logic mag_lt;
    logic mag_gt;

    always_comb begin
        mag_lt = a[W-2:0] < b[W-2:0];
        mag_gt = a[W-2:0] > b[W-2:0];
        ord.eq = (a == b) || (a_zero && b_zero);
        if (ord.eq) begin
            ord.lt = 1'b0;
        end else if (a[W-1] != b[W-1]) begin
            ord.lt = a[W-1];
        end else if (!a[W-1]) begin
            ord.lt = mag_lt;
        end else begin
            ord.lt = mag_gt;
        end
        ord.gt = !ord.eq && !ord.lt;
    end
endmodule

// File: rtl/fcmp_mask_build.sv
module fcmp_mask_build
    import fcmp_pkg::*;
(
    input  logic              unord,
    input  fp_order_t         ord,
    input  logic              s1_zero,
    input  logic              s1_sign,
    input  logic              s2_sign,
    input  logic              legacy,
    output logic [MASK_W-1:0] mask
);
    always_comb begin
        mask = '0;
        if (unord) begin
            mask[B_UN]  = 1'b1;
            mask[B_NE]  = 1'b1;
            mask[B_UE]  = 1'b1;
            mask[B_UG]  = 1'b1;
            mask[B_ULE] = 1'b1;
            mask[B_UL]  = 1'b1;
            mask[B_UGE] = 1'b1;
        end else begin
            mask[B_ORD] = 1'b1;
            mask[B_EQ]  = ord.eq;
            mask[B_NE]  = !ord.eq;
            mask[B_GT]  = ord.gt;
            mask[B_LT]  = ord.lt;
            mask[B_LE]  = ord.eq || ord.lt;
            mask[B_GE]  = ord.eq || ord.gt;
            mask[B_UE]  = ord.eq;
            mask[B_LG]  = ord.lt || ord.gt;
            mask[B_UG]  = ord.gt;
            mask[B_ULE] = ord.eq || ord.lt;
            mask[B_UL]  = ord.lt;
            mask[B_UGE] = ord.eq || ord.gt;
            if (!s2_sign) begin
                if (ord.eq || s1_zero) begin
                    mask[B_IB] = 1'b1;
                    mask[B_OB] = 1'b1;
                end else if (ord.gt || s1_sign) begin
                    mask[B_OU] = 1'b1;
                    mask[B_OB] = 1'b1;
                end else begin
                    mask[B_IB] = 1'b1;
                    mask[B_IN] = 1'b1;
                end
            end
        end
        if (legacy) begin
            mask[EXT_HI:EXT_LO] = '0;
        end
    end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dbl_sel,
    input  logic              quiet_cmp,
    input  logic              legacy,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic [MASK_W-1:0] mask_q,
    output logic              invalid_q,
    output logic              wr_en_q,
    output logic [IDX_W-1:0]  dst_q
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              invalid;
        logic              wr_en;
        logic [IDX_W-1:0]  dst;
    } state_t;

    state_t st_d, st_q;

    logic [63:0] ops [NOPS];
    fp_class_t   cls_s [NOPS];
    fp_class_t   cls_d [NOPS];
    fp_class_t   cls   [NOPS];
    fp_order_t   ord_s, ord_d, ord;
    logic        unord;
    logic [MASK_W-1:0] mask_w;

    assign ops[0] = opa;
    assign ops[1] = opb;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fcmp_classify #(.EXP_W(8), .FRAC_W(23)) u_cls_s (
            .val (ops[i][31:0]),
            .cls (cls_s[i])
        );
        fcmp_classify #(.EXP_W(11), .FRAC_W(52)) u_cls_d (
            .val (ops[i]),
            .cls (cls_d[i])
        );
        assign cls[i] = dbl_sel ? cls_d[i] : cls_s[i];
    end

    fcmp_order #(.W(32)) u_ord_s (
        .a      (opa[31:0]),
        .b      (opb[31:0]),
        .a_zero (cls_s[0].zero),
        .b_zero (cls_s[1].zero),
        .ord    (ord_s)
    );

    fcmp_order #(.W(64)) u_ord_d (
        .a      (opa),
        .b      (opb),
        .a_zero (cls_d[0].zero),
        .b_zero (cls_d[1].zero),
        .ord    (ord_d)
    );

    assign ord   = dbl_sel ? ord_d : ord_s;
    assign unord = cls[0].nan || cls[1].nan;

    fcmp_mask_build u_mask (
        .unord   (unord),
        .ord     (ord),
        .s1_zero (cls[0].zero),
        .s1_sign (cls[0].sign),
        .s2_sign (cls[1].sign),
        .legacy  (legacy),
        .mask    (mask_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = mask_w;
        st_d.dst  = dst_idx;
        st_d.wr_en = in_valid && (dst_idx != '0);
        if (!in_valid) begin
            st_d.invalid = 1'b0;
        end else if (cls[0].nan) begin
            st_d.invalid = !quiet_cmp || cls[0].snan;
        end else if (cls[1].nan) begin
            st_d.invalid = !quiet_cmp || cls[1].snan;
        end else begin
            st_d.invalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q    = st_q.mask;
    assign invalid_q = st_q.invalid;
    assign wr_en_q   = st_q.wr_en;
    assign dst_q     = st_q.dst;
endmodule

// File: rtl/fcmp_cond_unit_chk.sv
module fcmp_cond_unit_chk
    import fcmp_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              dbl_sel,
    input logic              legacy,
    input logic [63:0]       opb,
    input logic [MASK_W-1:0] mask_q,
    input logic              invalid_q,
    input logic              wr_en_q,
    input logic [IDX_W-1:0]  dst_q
);
    logic s2_neg;
    assign s2_neg = dbl_sel ? opb[63] : opb[31];

    assert_wr_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> (dst_q != '0));

    assert_no_inv_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !invalid_q);

    assert_inv_unord_R5: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_q |-> mask_q[B_UN]);

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones({mask_q[B_UN], mask_q[B_EQ], mask_q[B_LT], mask_q[B_GT]}) == 1));

    assert_interval_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask_q[B_IN], mask_q[B_OU]}) && !(mask_q[B_IB] && mask_q[B_OU]));

    assert_no_interval_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && s2_neg) |=> (mask_q[B_OB:B_OU] == 4'b0));

    assert_legacy_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legacy) |=> (mask_q[EXT_HI:EXT_LO] == '0));

    assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[MASK_W-1:EXT_HI+1] == '0);
endmodule

bind fcmp_cond_unit fcmp_cond_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dbl_sel   (dbl_sel),
    .legacy    (legacy),
    .opb       (opb),
    .mask_q    (mask_q),
    .invalid_q (invalid_q),
    .wr_en_q   (wr_en_q),
    .dst_q     (dst_q)
);

// File: tb/fcmp_cond_unit_tb.sv
module fcmp_cond_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dbl_sel = 1'b0;
    logic        quiet_cmp = 1'b0;
    logic        legacy = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [4:0]  dst_idx = '0;
    logic [31:0] mask_q;
    logic        invalid_q;
    logic        wr_en_q;
    logic [4:0]  dst_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fcmp_cond_unit u_dut (
        .clk, .rst_n, .in_valid, .dbl_sel, .quiet_cmp, .legacy,
        .opa, .opb, .dst_idx, .mask_q, .invalid_q, .wr_en_q, .dst_q
    );

    // {dbl, quiet, legacy, s1, s2, expected mask, expected invalid}
    localparam int NV = 21;
    localparam logic [163:0] VEC [NV] = '{
        {3'b000, 64'h3F800000, 64'h40000000, 32'h0001A66A, 1'b0}, // R8 in range
        {3'b000, 64'h40000000, 64'h3F800000, 32'h0002699A, 1'b0}, // R8 above
        {3'b000, 64'h3F800000, 64'h3F800000, 32'h00029AA6, 1'b0}, // R6 equal
        {3'b000, 64'hBF800000, 64'h40000000, 32'h0001A96A, 1'b0}, // R7 neg s1
        {3'b000, 64'hC0000000, 64'hBF800000, 32'h0001A06A, 1'b0}, // R7 neg reversed
        {3'b000, 64'hBF800000, 64'hC0000000, 32'h0002609A, 1'b0}, // R9
        {3'b000, 64'h80000000, 64'h00000000, 32'h00029AA6, 1'b0}, // R7 signed zero
        {3'b000, 64'h00000000, 64'h80000000, 32'h000290A6, 1'b0}, // R9 -0 s2
        {3'b000, 64'h00000000, 64'h40000000, 32'h0001AA6A, 1'b0}, // R8 zero s1
        {3'b000, 64'h7F800000, 64'h3F800000, 32'h0002699A, 1'b0}, // R7 inf
        {3'b000, 64'h7FC00000, 64'h3F800000, 32'h0003D009, 1'b1}, // R4 R5 strict
        {3'b010, 64'h7FC00000, 64'h3F800000, 32'h0003D009, 1'b0}, // R5 quiet qnan
        {3'b010, 64'h3F800000, 64'h7F800001, 32'h0003D009, 1'b1}, // R3 snan s2
        {3'b010, 64'h7FC00000, 64'h7F800001, 32'h0003D009, 1'b0}, // R5 s1 first
        {3'b000, 64'h3F800000, 64'h7FC00000, 32'h0003D009, 1'b1}, // R5 s2 nan strict
        {3'b001, 64'h3F800000, 64'h40000000, 32'h0000066A, 1'b0}, // R10
        {3'b001, 64'h7FC00000, 64'h3F800000, 32'h00000009, 1'b1}, // R10 unord
        {3'b100, 64'h3FF0000000000000, 64'h4000000000000000, 32'h0001A66A, 1'b0}, // R3 dbl
        {3'b100, 64'h4000000000000000, 64'hBFF0000000000000, 32'h0002609A, 1'b0}, // R9 dbl
        {3'b110, 64'h7FF0000000000001, 64'h3FF0000000000000, 32'h0003D009, 1'b1}, // R3 dbl snan
        {3'b000, 64'hFFFFFFFF3F800000, 64'h7FF0000040000000, 32'h0001A66A, 1'b0}  // R11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mask", mask_q, 32'h0);
        chk("R1 wr_en", {31'b0, wr_en_q}, 32'h0);
        chk("R1 invalid", {31'b0, invalid_q}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {dbl_sel, quiet_cmp, legacy} = VEC[i][163:161];
            opa = VEC[i][160:97];
            opb = VEC[i][96:33];
            in_valid = 1'b1;
            dst_idx  = 5'd7;
            @(negedge clk);
            chk($sformatf("R4/R6/R8 mask vec %0d", i), mask_q, VEC[i][32:1]);
            chk($sformatf("R5 invalid vec %0d", i), {31'b0, invalid_q}, {31'b0, VEC[i][0]});
            chk($sformatf("R12 upper vec %0d", i), {18'b0, mask_q[31:18]}, 32'h0);
        end

        // R2: write enable and index echo
        chk("R2 wr_en", {31'b0, wr_en_q}, 32'h1);
        chk("R2 dst", {27'b0, dst_q}, 32'd7);
        @(negedge clk);
        dst_idx = 5'd0;
        {dbl_sel, quiet_cmp, legacy} = 3'b000;
        opa = 64'h7FC00000; opb = 64'h3F800000;
        @(negedge clk);
        chk("R2 wr_en dst zero", {31'b0, wr_en_q}, 32'h0);
        chk("R2 mask still computed", mask_q, 32'h0003D009);
        dst_idx = 5'd9;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle wr_en", {31'b0, wr_en_q}, 32'h0);
        chk("R2 idle invalid", {31'b0, invalid_q}, 32'h0);

        // R1: reset mid-run clears outputs
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset mask", mask_q, 32'h0);
        chk("R1 mid reset dst", {27'b0, dst_q}, 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule